// File: doc/BRIEF.md
# Packed Fuse Map Expander

This block converts a compacted one-time-programmable image into a flat logical byte map. The physical image holds a sequence of variable-length packets. Each packet starts with a two-byte header that names a logical block and says which of that block's four 16-bit words follow. The expander walks the image, decodes every header, and scatters the data bytes that follow it to their logical positions. Logical bytes that no packet mentions keep the erased value 0xFF.

A single `start` pulse runs one complete expansion. The block first erases the whole logical memory through its write port. It then reads the physical image one byte at a time through a synchronous read port. Each read has one cycle of latency. The expansion ends on an erased header byte, or when the scan pointer reaches the reserved tail region. It also ends with an error flag when a packet would overrun either map. Both maps are outside the block: a read port faces the physical image and a write port faces the logical memory, so each can be an inferred block RAM.

Top module: `fuse_map_expander`

## Requirements
- R1: After an accepted `start`, the first LOG_SIZE logical writes store 0xFF at addresses 0, 1, 2 … LOG_SIZE-1 in ascending order, and no physical read is issued before the last of them.
- R2: The scan begins at physical address RSV_SIZE. Bytes below RSV_SIZE are never interpreted as a header.
- R3: A header whose first or second byte is 0xFF ends the expansion with `done` and `err` low.
- R4: The 8-bit block index is formed as {first_byte[3:0], second_byte[7:4]}. The upper nibble of the first byte is ignored.
- R5: second_byte[3:0] is an active-low word mask: bit w = 0 means word w is present. Present words are taken in ascending order, and each consumes the next two physical bytes.
- R6: The two bytes of present word w of block b are written to logical addresses b*8 + w*2 and b*8 + w*2 + 1, in that order.
- R7: When the scan pointer at a header boundary reaches PHY_SIZE-RSV_SIZE, the expansion ends with `err` low, and no byte at or above that limit is read as data.
- R8: A present word whose first byte would sit at or above PHY_SIZE-RSV_SIZE-1 ends the expansion with `err` high, and that word is not written.
- R9: A present word whose logical address b*8 + w*2 is not below LOG_SIZE ends the expansion with `err` high, and that word is not written.
- R10: When two packets name the same block and word, the bytes of the later packet remain in the logical map.
- R11: `busy` is high from the cycle after an accepted `start` until `done`. `done` is a one-cycle pulse. `err` holds its value until the next accepted `start`. A `start` pulse while `busy` is high is ignored.
- R12: Physical read data is taken in the second cycle after `phy_rd_en` is seen high. Read requests are never issued in two consecutive cycles. No port activity happens while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that starts one expansion |
| phy_rd_en | output | 1 | Physical image read request |
| phy_rd_addr | output | $clog2(PHY_SIZE) | Physical byte address |
| phy_rd_data | input | 8 | Read data, valid the cycle after the request is sampled |
| log_wr_en | output | 1 | Logical memory write strobe |
| log_wr_addr | output | $clog2(LOG_SIZE) | Logical byte address |
| log_wr_data | output | 8 | Logical write data |
| busy | output | 1 | Expansion in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last expansion stopped on a bounds violation |

## Verification
Two situations are hard to reach. The first is a packet that straddles the end of the usable physical region. The second is a scan that lands exactly on that limit with no terminator. Both need the image to be packed solid up to the last few bytes. The stimulus builds such an image from fourteen one-word packets that end exactly at a header slot near the limit. The last packet is then chosen either to fit exactly or to overrun by one word. The logical bound is reached with a block index whose high nibble comes from the first header byte. The last legal word is written next to the first illegal one, so both sides of the limit are tested in one run.

// File: rtl/fme_pkg.sv
package fme_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FILL,
    ST_SCAN,
    ST_H0W,
    ST_H0,
    ST_H1W,
    ST_H1,
    ST_WORD,
    ST_D0W,
    ST_D0,
    ST_D1W,
    ST_D1,
    ST_FIN
  } fme_state_t;

  typedef struct packed {
    logic [7:0] blk;
    logic [3:0] absent;
    logic       term;
  } fme_hdr_t;

  localparam int WORDS_PER_BLK = 4;
  localparam logic [7:0] ERASED = 8'hFF;

endpackage

// File: rtl/fme_hdr_decode.sv
module fme_hdr_decode
  import fme_pkg::*;
(
  input  logic [7:0] first_b,
  input  logic [7:0] second_b,
  output fme_hdr_t   hdr
);
  always_comb begin
    hdr.blk    = {first_b[3:0], second_b[7:4]};
    hdr.absent = second_b[3:0];
    hdr.term   = (first_b == ERASED) || (second_b == ERASED);
  end
endmodule

// File: rtl/fme_word_pick.sv
module fme_word_pick #(
  parameter int NW = 4,
  localparam int IW = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic [NW-1:0] pending,
  output logic          found,
  output logic [IW-1:0] idx
);
  logic [NW-1:0] lower_clear;

  generate
    for (genvar g = 0; g < NW; g++) begin : g_pri
      if (g == 0) begin : g_first
        assign lower_clear[g] = 1'b1;
      end else begin : g_rest
        assign lower_clear[g] = lower_clear[g-1] & ~pending[g-1];
      end
    end
  endgenerate

  always_comb begin
    found = |pending;
    idx   = '0;
    for (int i = 0; i < NW; i++) begin
      if (pending[i] && lower_clear[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/fme_fill_ctr.sv
module fme_fill_ctr #(
  parameter int DEPTH = 160,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          en,
  output logic [AW-1:0] cnt,
  output logic          last
);
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (en)    cnt <= cnt + AW'(1);
  end
  assign last = (cnt == AW'(DEPTH - 1));
endmodule

// File: rtl/fuse_map_expander.sv
module fuse_map_expander
  import fme_pkg::*;
#(
  parameter int PHY_SIZE = 64,
  parameter int LOG_SIZE = 160,
  parameter int RSV_SIZE = 2,
  localparam int PA = $clog2(PHY_SIZE),
  localparam int LA = $clog2(LOG_SIZE)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          phy_rd_en,
  output logic [PA-1:0] phy_rd_addr,
  input  logic [7:0]    phy_rd_data,
  output logic          log_wr_en,
  output logic [LA-1:0] log_wr_addr,
  output logic [7:0]    log_wr_data,
  output logic          busy,
  output logic          done,
  output logic          err
);
  localparam int LIM = PHY_SIZE - RSV_SIZE;
  localparam int PW  = $clog2(PHY_SIZE + 2);
  localparam int XW  = 12;

  fme_state_t      st;
  logic [PW-1:0]   ptr;
  logic [7:0]      hdr0_q;
  logic [7:0]      blk_q;
  logic [WORDS_PER_BLK-1:0] pend_q;
  logic [XW-1:0]   lidx_q;
  logic            fail_q;

  fme_hdr_t        hdr;
  logic            pick_found;
  logic [1:0]      pick_idx;
  logic [LA-1:0]   fill_cnt;
  logic            fill_last;
  logic            fill_clr;
  logic            fill_en;
  logic [XW-1:0]   cand_lidx;

  fme_hdr_decode u_hdr (
    .first_b (hdr0_q),
    .second_b(phy_rd_data),
    .hdr     (hdr)
  );

  fme_word_pick #(.NW(WORDS_PER_BLK)) u_pick (
    .pending(pend_q),
    .found  (pick_found),
    .idx    (pick_idx)
  );

  assign fill_clr = (st == ST_IDLE);
  assign fill_en  = (st == ST_FILL);

  fme_fill_ctr #(.DEPTH(LOG_SIZE)) u_fill (
    .clk (clk),
    .rst (rst),
    .clr (fill_clr),
    .en  (fill_en),
    .cnt (fill_cnt),
    .last(fill_last)
  );

  assign cand_lidx = {1'b0, blk_q, pick_idx, 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      ptr         <= '0;
      hdr0_q      <= '0;
      blk_q       <= '0;
      pend_q      <= '0;
      lidx_q      <= '0;
      fail_q      <= 1'b0;
      phy_rd_en   <= 1'b0;
      phy_rd_addr <= '0;
      log_wr_en   <= 1'b0;
      log_wr_addr <= '0;
      log_wr_data <= '0;
      busy        <= 1'b0;
      done        <= 1'b0;
      err         <= 1'b0;
    end else begin
      phy_rd_en <= 1'b0;
      log_wr_en <= 1'b0;
      done      <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            busy   <= 1'b1;
            err    <= 1'b0;
            fail_q <= 1'b0;
            ptr    <= PW'(RSV_SIZE);
            st     <= ST_FILL;
          end
        end
        ST_FILL: begin
          log_wr_en   <= 1'b1;
          log_wr_addr <= fill_cnt;
          log_wr_data <= ERASED;
          if (fill_last) st <= ST_SCAN;
        end
        ST_SCAN: begin
          if (ptr < PW'(LIM)) begin
            phy_rd_en   <= 1'b1;
            phy_rd_addr <= ptr[PA-1:0];
            st          <= ST_H0W;
          end else begin
            st <= ST_FIN;
          end
        end
        ST_H0W: st <= ST_H0;
        ST_H0: begin
          hdr0_q      <= phy_rd_data;
          phy_rd_en   <= 1'b1;
          phy_rd_addr <= PA'(ptr + PW'(1));
          st          <= ST_H1W;
        end
        ST_H1W: st <= ST_H1;
        ST_H1: begin
          if (hdr.term) begin
            st <= ST_FIN;
          end else begin
            blk_q  <= hdr.blk;
            pend_q <= ~hdr.absent;
            ptr    <= ptr + PW'(2);
            st     <= ST_WORD;
          end
        end
        ST_WORD: begin
          if (!pick_found) begin
            st <= ST_SCAN;
          end else if (ptr >= PW'(LIM - 1) || cand_lidx >= XW'(LOG_SIZE)) begin
            fail_q <= 1'b1;
            st     <= ST_FIN;
          end else begin
            pend_q[pick_idx] <= 1'b0;
            lidx_q           <= cand_lidx;
            phy_rd_en        <= 1'b1;
            phy_rd_addr      <= ptr[PA-1:0];
            st               <= ST_D0W;
          end
        end
        ST_D0W: st <= ST_D0;
        ST_D0: begin
          log_wr_en   <= 1'b1;
          log_wr_addr <= lidx_q[LA-1:0];
          log_wr_data <= phy_rd_data;
          phy_rd_en   <= 1'b1;
          phy_rd_addr <= PA'(ptr + PW'(1));
          st          <= ST_D1W;
        end
        ST_D1W: st <= ST_D1;
        ST_D1: begin
          log_wr_en   <= 1'b1;
          log_wr_addr <= {lidx_q[LA-1:1], 1'b1};
          log_wr_data <= phy_rd_data;
          ptr         <= ptr + PW'(2);
          st          <= ST_WORD;
        end
        ST_FIN: begin
          busy <= 1'b0;
          done <= 1'b1;
          err  <= fail_q;
          st   <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fme_checker.sv
module fme_checker #(
  parameter int PHY_SIZE = 64,
  parameter int LOG_SIZE = 160,
  parameter int RSV_SIZE = 2,
  localparam int PA = $clog2(PHY_SIZE),
  localparam int LA = $clog2(LOG_SIZE)
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          phy_rd_en,
  input logic [PA-1:0] phy_rd_addr,
  input logic          log_wr_en,
  input logic [LA-1:0] log_wr_addr,
  input logic          busy,
  input logic          done
);
  p_rd_spacing_r12: assert property (@(posedge clk) disable iff (rst)
    phy_rd_en |=> !phy_rd_en);

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!phy_rd_en && !log_wr_en));

  p_rd_window_r2: assert property (@(posedge clk) disable iff (rst)
    phy_rd_en |-> (int'(phy_rd_addr) >= RSV_SIZE && int'(phy_rd_addr) <= PHY_SIZE - RSV_SIZE));

  p_wr_in_map_r9: assert property (@(posedge clk) disable iff (rst)
    log_wr_en |-> (int'(log_wr_addr) < LOG_SIZE));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_start_accept_r11: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !done) |=> busy);

  p_done_ends_busy_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

bind fuse_map_expander fme_checker #(
  .PHY_SIZE(PHY_SIZE),
  .LOG_SIZE(LOG_SIZE),
  .RSV_SIZE(RSV_SIZE)
) u_fme_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .phy_rd_en  (phy_rd_en),
  .phy_rd_addr(phy_rd_addr),
  .log_wr_en  (log_wr_en),
  .log_wr_addr(log_wr_addr),
  .busy       (busy),
  .done       (done)
);

// File: tb/tb_fuse_map_expander.sv
module tb_fuse_map_expander;
  localparam int PHY = 64;
  localparam int LOG = 160;
  localparam int RSV = 2;
  localparam int PA  = $clog2(PHY);
  localparam int LA  = $clog2(LOG);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          phy_rd_en;
  logic [PA-1:0] phy_rd_addr;
  logic [7:0]    phy_rd_data = 8'h00;
  logic          log_wr_en;
  logic [LA-1:0] log_wr_addr;
  logic [7:0]    log_wr_data;
  logic          busy, done, err;

  int n_chk = 0;
  int n_fail = 0;

  logic [7:0] phy [PHY];
  logic [7:0] logm [LOG];
  logic       mon_clr = 1'b0;
  int         wcnt;
  int         max_rd;
  logic       seen_rd;
  logic       fill_bad;
  logic       done_q;
  logic       dbl_done;

  always #5 clk = ~clk;

  fuse_map_expander #(.PHY_SIZE(PHY), .LOG_SIZE(LOG), .RSV_SIZE(RSV)) dut (
    .clk(clk), .rst(rst), .start(start),
    .phy_rd_en(phy_rd_en), .phy_rd_addr(phy_rd_addr), .phy_rd_data(phy_rd_data),
    .log_wr_en(log_wr_en), .log_wr_addr(log_wr_addr), .log_wr_data(log_wr_data),
    .busy(busy), .done(done), .err(err)
  );

  always @(posedge clk) begin
    if (phy_rd_en) phy_rd_data <= phy[phy_rd_addr];
  end

  always @(posedge clk) begin
    if (mon_clr) begin
      for (int i = 0; i < LOG; i++) logm[i] <= 8'h00;
      wcnt <= 0; max_rd <= -1; seen_rd <= 1'b0; fill_bad <= 1'b0;
      done_q <= 1'b0; dbl_done <= 1'b0;
    end else begin
      done_q <= done;
      if (done && done_q) dbl_done <= 1'b1;
      if (phy_rd_en) begin
        seen_rd <= 1'b1;
        if (int'(phy_rd_addr) > max_rd) max_rd <= int'(phy_rd_addr);
      end
      if (log_wr_en) begin
        if (wcnt < LOG && (int'(log_wr_addr) != wcnt || log_wr_data != 8'hFF || seen_rd))
          fill_bad <= 1'b1;
        logm[log_wr_addr] <= log_wr_data;
        wcnt <= wcnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic img_erase();
    for (int i = 0; i < PHY; i++) phy[i] = 8'hFF;
  endtask

  task automatic run();
    int t;
    @(negedge clk); mon_clr = 1'b1;
    @(negedge clk); mon_clr = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    t = 0;
    while (!done && t < 5000) begin @(negedge clk); t++; end
    chk(done, "R11 done seen", int'(done), 1);
    @(negedge clk);
    chk(!busy && !done, "R11 done one pulse, busy low", int'({busy, done}), 0);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !err && !phy_rd_en && !log_wr_en, "reset state",
        int'({busy, done, err, phy_rd_en, log_wr_en}), 0);
  endtask

  task automatic t_empty();
    img_erase();
    phy[0] = 8'h00; phy[1] = 8'h0E;
    run();
    chk(!err, "R3 erased header no error", int'(err), 0);
    chk(!fill_bad, "R1 ascending 0xFF fill before reads", int'(fill_bad), 0);
    chk(wcnt == LOG, "R2 reserved bytes not decoded", wcnt, LOG);
    chk(logm[0] == 8'hFF && logm[LOG-1] == 8'hFF, "R1 erased map", int'(logm[0]), 8'hFF);
    chk(!dbl_done, "R11 done single cycle", int'(dbl_done), 0);
  endtask

  task automatic t_basic();
    img_erase();
    phy[2] = 8'h00; phy[3] = 8'h30;
    for (int i = 0; i < 8; i++) phy[4+i] = 8'(8'h30 + i);
    phy[12] = 8'h00; phy[13] = 8'h5A;
    phy[14] = 8'hA0; phy[15] = 8'hA1; phy[16] = 8'hA2; phy[17] = 8'hA3;
    run();
    for (int i = 0; i < 8; i++)
      chk(logm[24+i] == 8'(8'h30 + i), "R6 block 3 word bytes", int'(logm[24+i]), 8'h30 + i);
    chk(logm[40] == 8'hA0 && logm[41] == 8'hA1, "R5 word0 present", int'(logm[40]), 8'hA0);
    chk(logm[44] == 8'hA2 && logm[45] == 8'hA3, "R5 word2 uses next bytes", int'(logm[44]), 8'hA2);
    chk(logm[42] == 8'hFF && logm[46] == 8'hFF, "R5 absent words stay erased", int'(logm[42]), 8'hFF);
    chk(wcnt == LOG + 12 && !err, "R3 stop on first byte 0xFF", wcnt, LOG + 12);
    chk(!fill_bad, "R1 fill order", int'(fill_bad), 0);
  endtask

  task automatic t_hi_nibble();
    img_erase();
    phy[2] = 8'hF1; phy[3] = 8'h2E; phy[4] = 8'h5A; phy[5] = 8'hA5;
    run();
    chk(logm[144] == 8'h5A && logm[145] == 8'hA5, "R4 block index 0x12", int'(logm[144]), 8'h5A);
    chk(logm[16] == 8'hFF && !err, "R4 low nibble only", int'(logm[16]), 8'hFF);
  endtask

  task automatic t_repeat();
    img_erase();
    phy[2] = 8'h00; phy[3] = 8'h1D; phy[4] = 8'hAA; phy[5] = 8'hBB;
    phy[6] = 8'h00; phy[7] = 8'h1D; phy[8] = 8'hCC; phy[9] = 8'hDD;
    phy[10] = 8'h00; phy[11] = 8'hFF;
    run();
    chk(logm[10] == 8'hCC && logm[11] == 8'hDD, "R10 last write wins", int'(logm[10]), 8'hCC);
    chk(logm[8] == 8'hFF && wcnt == LOG + 4 && !err, "R3 stop on second byte 0xFF", wcnt, LOG + 4);
  endtask

  task automatic t_log_bound();
    img_erase();
    phy[2] = 8'h01; phy[3] = 8'h37; phy[4] = 8'h11; phy[5] = 8'h22;
    phy[6] = 8'h01; phy[7] = 8'h4E; phy[8] = 8'h33; phy[9] = 8'h44;
    run();
    chk(logm[158] == 8'h11 && logm[159] == 8'h22, "R6 last legal word", int'(logm[158]), 8'h11);
    chk(err, "R9 logical overrun error", int'(err), 1);
    chk(wcnt == LOG + 2, "R9 overrun word not written", wcnt, LOG + 2);
  endtask

  task automatic pack_to_58();
    img_erase();
    for (int k = 0; k < 14; k++) begin
      phy[2+4*k] = 8'h00; phy[3+4*k] = 8'h0E;
      phy[4+4*k] = 8'(k); phy[5+4*k] = 8'(8'h40 + k);
    end
    phy[60] = 8'h77; phy[61] = 8'h88; phy[62] = 8'h00; phy[63] = 8'h0E;
  endtask

  task automatic t_phy_bound();
    pack_to_58();
    phy[58] = 8'h00; phy[59] = 8'h0C;
    run();
    chk(err, "R8 physical overrun error", int'(err), 1);
    chk(logm[0] == 8'h77 && logm[1] == 8'h88, "R8 fitting word kept", int'(logm[0]), 8'h77);
    chk(wcnt == LOG + 30 && max_rd == 61, "R8 overrun word not read", max_rd, 61);
  endtask

  task automatic t_clean_end();
    pack_to_58();
    phy[58] = 8'h00; phy[59] = 8'h0E;
    run();
    chk(!err, "R7 limit reached without error", int'(err), 0);
    chk(max_rd == 61 && wcnt == LOG + 30, "R7 tail not read", max_rd, 61);
    chk(logm[0] == 8'h77, "R12 read latency data", int'(logm[0]), 8'h77);
  endtask

  task automatic t_busy_start();
    img_erase();
    phy[2] = 8'h00; phy[3] = 8'h0E; phy[4] = 8'h12; phy[5] = 8'h34;
    @(negedge clk); mon_clr = 1'b1;
    @(negedge clk); mon_clr = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (20) @(negedge clk);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
    repeat (3) @(negedge clk);
    chk(!busy && wcnt == LOG + 2, "R11 start while busy ignored", wcnt, LOG + 2);
    chk(!err, "R11 err cleared by new start", int'(err), 0);
  endtask

  initial begin
    for (int i = 0; i < PHY; i++) phy[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_empty();
    t_basic();
    t_hi_nibble();
    t_repeat();
    t_log_bound();
    t_phy_bound();
    t_busy_start();
    t_clean_end();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule